// File: doc/BRIEF.md
# Paired 4-bit GPIO Port Controller

This block holds two 4-bit general-purpose I/O ports behind a small register bus. Software sets, per pin, whether the pin is an input or an output, whether its pull-up is requested, and whether an output pin drives push-pull or open-drain. The block turns these settings into abstract pad-control signals: output enable, output value, pull-up enable and open-drain mode. It brings the pad input values back through a two-stage synchronizer.

Each bus access picks a register kind, a port and an access size. The size is a single bit, a whole nibble, or a paired 8-bit word that covers both ports at once. Bus reads are combinational from the current state. A write takes effect on the rising clock edge on which the strobe is sampled. Reset is synchronous and active low.

Top module: `gpio_pair`

## Requirements
- R1: After reset every direction, pull-up, open-drain and data latch bit is 0. All pins are inputs, `pad_oe` is 0 and `pad_pu` is 0.
- R2: `bus_addr[2:1]` selects the register: 00 = data, 01 = direction (1 = output), 10 = pull-up request, 11 = open-drain select. `bus_addr[0]` selects the port. With `bus_size` = 01 (nibble), a write loads `bus_wdata[3:0]` into the selected register. A read returns that register in `bus_rdata[3:0]`, with the upper bits 0.
- R3: With `bus_size` = 00 (bit), a write stores `bus_wdata[0]` into bit `bus_bit` of the selected register and leaves the other three bits unchanged. A read returns that bit in `bus_rdata[0]`, with all other bits 0.
- R4: With `bus_size` = 10 (pair), `bus_addr[0]` is ignored. Port 0 maps to data bits [3:0] and port 1 maps to bits [7:4], for both reads and writes. Pad vectors use the same layout: pin i of port p is bit 4p+i.
- R5: An output pin in push-pull mode has `pad_oe` = 1 and `pad_out` equal to its data latch.
- R6: `pad_pu` is the pull-up request gated by the pin being an input. An output pin always has `pad_pu` = 0.
- R7: An output pin in open-drain mode drives low (`pad_oe` = 1, `pad_out` = 0) when its latch is 0. It releases (`pad_oe` = 0) when its latch is 1. `pad_od` reflects the open-drain select.
- R8: A data-register read returns the latch for an output pin. For an input pin it returns the pad value delayed by two clock edges.
- R9: A cycle with `bus_sel` low, or with `bus_we` low, changes no register.
- R10: `bus_size` = 11 is reserved. A write with this size changes nothing, and a read with this size returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register kind [2:1], port [0] |
| bus_size | input | 2 | 00 bit, 01 nibble, 10 pair, 11 reserved |
| bus_bit | input | 2 | Bit index for bit accesses |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pad input values |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_od | output | 8 | Pad open-drain mode |

## Verification
The data and pad behaviour is driven with one mixed configuration: one port has every pin as an output, with push-pull and open-drain pins interleaved and latch values of both polarities. This separates each of the four combinations of mode and latch value. The pull-up gating is seen by flipping a port between all-output and all-input while its pull-up request stays constant. The pad input is stepped once, and the value read back is checked one edge and two edges after the step. This shows the synchronizer depth. Bit, nibble and pair accesses are mixed over the same registers, with the port-select bit set against the pair access, so that a wrong lane or a wrong mask shows up in a later read.

// File: rtl/gpio_pkg.sv
// Shared encodings for the paired GPIO block.
// Assumes the bus decoder and the port slices agree on these values.
package gpio_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'b00,
        REG_DIR  = 2'b01,
        REG_PULL = 2'b10,
        REG_ODRN = 2'b11
    } reg_kind_e;

    typedef enum logic [1:0] {
        SZ_BIT  = 2'b00,
        SZ_NIB  = 2'b01,
        SZ_PAIR = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of pad inputs.
// Assumes STAGES >= 1; every stage resets to 0.
module gpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pad sample one stage further on each edge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[s] <= '0;
                else if (s == 0)
                    stg[s] <= d;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// One GPIO port slice: four control registers, pad-control derivation
// and per-pin readback. Writes are masked, so a single-bit write only
// touches the bits that wr_mask selects. Assumes synchronous active-low reset.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    wr_kind,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    input  reg_kind_e    rd_kind,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_od
);
    logic [W-1:0] data_q, dir_q, pull_q, odrn_q;
    logic [W-1:0] pin_sync;

    function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                           input logic [W-1:0] mask,
                                           input logic [W-1:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

    // Output data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (wr_en && wr_kind == REG_DATA) data_q <= merge(data_q, wr_mask, wr_val);
    end

    // Direction register, 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else if (wr_en && wr_kind == REG_DIR) dir_q <= merge(dir_q, wr_mask, wr_val);
    end

    // Pull-up request register.
    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= '0;
        else if (wr_en && wr_kind == REG_PULL) pull_q <= merge(pull_q, wr_mask, wr_val);
    end

    // Open-drain select register.
    always_ff @(posedge clk) begin
        if (!rst_n) odrn_q <= '0;
        else if (wr_en && wr_kind == REG_ODRN) odrn_q <= merge(odrn_q, wr_mask, wr_val);
    end

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    // Pad controls: open-drain pins only ever pull low.
    always_comb begin
        pad_oe  = dir_q & (~odrn_q | ~data_q);
        pad_out = data_q & ~odrn_q;
        pad_pu  = pull_q & ~dir_q;
        pad_od  = odrn_q;
    end

    // Readback: the data register shows the latch for outputs and the pad for inputs.
    always_comb begin
        unique case (rd_kind)
            REG_DATA: rd_val = (dir_q & data_q) | (~dir_q & pin_sync);
            REG_DIR:  rd_val = dir_q;
            REG_PULL: rd_val = pull_q;
            REG_ODRN: rd_val = odrn_q;
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pair.sv
// Top of the paired GPIO block: decodes bus accesses (bit, nibble, pair)
// into masked writes for two port slices and muxes read data.
// Assumes reads are combinational and writes land on the sampling edge.
module gpio_pair
    import gpio_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BIT_W      = $clog2(PORT_W),
    localparam int PAIR_W     = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [BIT_W-1:0]  bus_bit,
    input  logic [PAIR_W-1:0] bus_wdata,
    output logic [PAIR_W-1:0] bus_rdata,
    input  logic [PAIR_W-1:0] pad_in,
    output logic [PAIR_W-1:0] pad_oe,
    output logic [PAIR_W-1:0] pad_out,
    output logic [PAIR_W-1:0] pad_pu,
    output logic [PAIR_W-1:0] pad_od
);
    acc_size_e        size;
    reg_kind_e        kind;
    logic             psel;
    logic [PORT_W-1:0] bit_mask;
    logic [PORT_W-1:0] rd_port [2];

    assign size     = acc_size_e'(bus_size);
    assign kind     = reg_kind_e'(bus_addr[2:1]);
    assign psel     = bus_addr[0];
    assign bit_mask = PORT_W'(1) << bus_bit;

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_port
            logic              hit;
            logic              wen;
            logic [PORT_W-1:0] mask;
            logic [PORT_W-1:0] val;

            // Decide whether this port is written and with which mask and lane.
            always_comb begin
                hit  = (size == SZ_PAIR) ||
                       ((size == SZ_BIT || size == SZ_NIB) && (psel == 1'(p)));
                wen  = bus_sel && bus_we && hit;
                mask = (size == SZ_BIT) ? bit_mask : '1;
                if (size == SZ_BIT)
                    val = {PORT_W{bus_wdata[0]}};
                else if (size == SZ_PAIR)
                    val = bus_wdata[p*PORT_W +: PORT_W];
                else
                    val = bus_wdata[PORT_W-1:0];
            end

            gpio_port #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wen),
                .wr_kind (kind),
                .wr_mask (mask),
                .wr_val  (val),
                .rd_kind (kind),
                .pad_in  (pad_in[p*PORT_W +: PORT_W]),
                .rd_val  (rd_port[p]),
                .pad_oe  (pad_oe[p*PORT_W +: PORT_W]),
                .pad_out (pad_out[p*PORT_W +: PORT_W]),
                .pad_pu  (pad_pu[p*PORT_W +: PORT_W]),
                .pad_od  (pad_od[p*PORT_W +: PORT_W])
            );
        end
    endgenerate

    // Read data mux by access size.
    always_comb begin
        bus_rdata = '0;
        unique case (size)
            SZ_BIT:  bus_rdata[0] = psel ? rd_port[1][bus_bit] : rd_port[0][bus_bit];
            SZ_NIB:  bus_rdata[PORT_W-1:0] = psel ? rd_port[1] : rd_port[0];
            SZ_PAIR: bus_rdata = {rd_port[1], rd_port[0]};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pair_chk.sv
// Property checker for gpio_pair, attached through bind below.
// Observes only the top-level ports.
module gpio_pair_chk #(
    parameter int PORT_W = 4,
    localparam int BIT_W  = $clog2(PORT_W),
    localparam int PAIR_W = 2 * PORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [1:0]        bus_size,
    input logic [BIT_W-1:0]  bus_bit,
    input logic [PAIR_W-1:0] bus_wdata,
    input logic [PAIR_W-1:0] bus_rdata,
    input logic [PAIR_W-1:0] pad_in,
    input logic [PAIR_W-1:0] pad_oe,
    input logic [PAIR_W-1:0] pad_out,
    input logic [PAIR_W-1:0] pad_pu,
    input logic [PAIR_W-1:0] pad_od
);
    assert_pu_off_when_driving_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_od & pad_out) == '0);

    assert_bit_read_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_size == 2'b00 |-> bus_rdata[PAIR_W-1:1] == '0);

    assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> ($stable(pad_oe) && $stable(pad_out) &&
                                  $stable(pad_pu) && $stable(pad_od)));

    assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_size == 2'b11 |=> ($stable(pad_oe) && $stable(pad_out) &&
                               $stable(pad_pu) && $stable(pad_od)));

    assert_reserved_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_size == 2'b11 |-> bus_rdata == '0);
endmodule

bind gpio_pair gpio_pair_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/gpio_pair_tb.sv
module gpio_pair_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [1:0] bus_size = '0, bus_bit = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pad_in = '0, pad_oe, pad_out, pad_pu, pad_od;
    int vectors = 0, errors = 0;
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pair u_dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic port, input logic [1:0] sz,
                      input logic [1:0] b, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = {kind, port}; bus_size = sz; bus_bit = b; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_size = 2'b01;
    endtask

    task automatic rdb(input logic [1:0] kind, input logic port, input logic [1:0] sz,
                       input logic [1:0] b, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = {kind, port}; bus_size = sz; bus_bit = b;
        #1 d = bus_rdata;
        bus_sel = 0; bus_size = 2'b01;
    endtask

    task automatic t_reset;
        rdb(2'b01, 0, 2'b10, 0, rd); check("R1 dir pair", rd, 8'h00);
        rdb(2'b10, 0, 2'b10, 0, rd); check("R1 pull pair", rd, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
    endtask

    task automatic t_nibble;
        wr(2'b10, 1, 2'b01, 0, 8'hFA);
        rdb(2'b10, 1, 2'b01, 0, rd); check("R2 pull p1 nibble", rd, 8'h0A);
        wr(2'b11, 0, 2'b01, 0, 8'h05);
        rdb(2'b11, 0, 2'b01, 0, rd); check("R2 odrn p0 nibble", rd, 8'h05);
    endtask

    task automatic t_bit;
        wr(2'b10, 1, 2'b00, 0, 8'h01);
        rdb(2'b10, 1, 2'b01, 0, rd); check("R3 bit write merge", rd, 8'h0B);
        rdb(2'b10, 1, 2'b00, 2, rd); check("R3 bit read 0", rd, 8'h00);
        rdb(2'b10, 1, 2'b00, 3, rd); check("R3 bit read 1", rd, 8'h01);
    endtask

    task automatic t_pair_and_pads;
        wr(2'b00, 1, 2'b10, 0, 8'h3C);
        wr(2'b01, 1, 2'b10, 0, 8'hFF);
        rdb(2'b00, 1, 2'b10, 0, rd); check("R4 pair data readback", rd, 8'h3C);
        rdb(2'b00, 0, 2'b01, 0, rd); check("R4 low lane is port0", rd, 8'h0C);
        check("R5 R7 pad_oe mix", pad_oe, 8'hFB);
        check("R5 R7 pad_out mix", pad_out, 8'h38);
        check("R7 pad_od", pad_od, 8'h05);
        check("R6 pu gated by output", pad_pu, 8'h00);
        wr(2'b01, 1, 2'b01, 0, 8'h00);
        check("R6 pu on for inputs", pad_pu, 8'hB0);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pad_in = 8'h50;
        bus_sel = 1; bus_we = 0; bus_addr = 3'b001; bus_size = 2'b01;
        @(negedge clk); #1 check("R8 one edge not yet", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R8 two edges", bus_rdata, 8'h05);
        bus_sel = 0;
        rdb(2'b00, 1, 2'b00, 2, rd); check("R8 bit read input pin", rd, 8'h01);
        rdb(2'b00, 0, 2'b01, 0, rd); check("R8 output pin reads latch", rd, 8'h0C);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = 3'b010; bus_size = 2'b01; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 0; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        rdb(2'b01, 0, 2'b01, 0, rd); check("R9 dir p0 unchanged", rd, 8'h0F);
        wr(2'b01, 0, 2'b11, 0, 8'h00);
        rdb(2'b01, 0, 2'b01, 0, rd); check("R10 reserved write ignored", rd, 8'h0F);
        rdb(2'b01, 0, 2'b11, 0, rd); check("R10 reserved read zero", rd, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_nibble;
        t_bit;
        t_pair_and_pads;
        t_sync;
        t_ignored;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        vectors++; errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule